// File: doc/BRIEF.md
# I2C Bus Condition Status Monitor

This block watches the two wires of an I2C bus from inside the system clock domain and keeps three sticky flags. The first records that a start condition has happened. The second records that a stop condition has happened. The third records that a receiver pulled SDA low on the acknowledge clock. It also counts SCL rising edges within each byte. From that count it knows which edge is the ninth (acknowledge) clock and which edge opens the next byte. Each flag is set and cleared at exact points in the bus timing.

SCL and SDA are asynchronous to the system clock. A synchronizer chain samples them, and every line event is found by comparing the newest synchronized sample with the one before it. Two controls come from the host logic: an interface enable level, and a single-cycle bus-release pulse. Driving the bus, address matching, data shifting, arbitration and interrupts are not part of this block.

Top module: `i2c_cond_monitor`

## Requirements
- R1: The start flag `start_o` rises when SDA falls while SCL stays high. It is visible 3 system clocks after the line change.
- R2: The stop flag `stop_o` rises when SDA rises while SCL stays high.
- R3: On the 9th SCL rising edge of a byte, `ack_o` is set if SDA is low at that edge. If SDA is high at that edge, `ack_o` stays clear.
- R4: A stop condition clears `start_o` and `ack_o`.
- R5: `start_o` stays set through every clock of the address byte. `start_o` and `ack_o` both clear on the first SCL rising edge of the following byte, which is the edge after the 9th.
- R6: A one-cycle pulse on `rel_i` clears `start_o` and `ack_o` and leaves `stop_o` unchanged. If a set event falls in the same cycle as a clear event, the set wins.
- R7: A new start does not clear `stop_o`. `stop_o` clears on the first SCL rising edge after a start that was detected while `stop_o` was set.
- R8: While `en_i` is 0, all three flags and `bit_cnt_o` are held at 0. Line events seen in that time have no effect.
- R9: `bit_cnt_o` goes to 0 on a start or a stop condition. It counts SCL rising edges from 1 to 9, and the edge after 9 gives 1. `ack_slot_o` is 1 exactly when `bit_cnt_o` equals 9.
- R10: Reset (`rst_ni` low) clears all flags and the count to 0.
- R11: SDA changes made while SCL is low set none of the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable; 0 clears and holds all state |
| rel_i | input | 1 | One-cycle bus-release pulse |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| start_o | output | 1 | Start condition seen |
| stop_o | output | 1 | Stop condition seen |
| ack_o | output | 1 | Acknowledge seen on the 9th clock |
| bit_cnt_o | output | 4 | SCL rising edges counted in the current byte (0 to 9) |
| ack_slot_o | output | 1 | High while the count sits on the acknowledge clock |

## Verification
A change on a bus line shows up in the flags and the count 3 system clocks later: two synchronizer stages, then the flag register. A `rel_i` pulse or a drop of `en_i` takes effect after 1 clock. The bench changes one line at a time on a falling clock edge, waits 4 clocks, and then compares every output against a bench model on a falling edge. In one directed probe, the start flag is sampled after exactly 2 and exactly 3 rising edges, which pins the 3-cycle latency.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  typedef struct packed {
    logic start;     // SDA fell while SCL high
    logic stop;      // SDA rose while SCL high
    logic scl_rise;  // SCL rising edge
    logic sda;       // synchronized SDA level
  } bus_ev_t;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output i2c_mon_pkg::bus_ev_t ev_o
);
  // bit 1 = SCL, bit 0 = SDA; idle bus is high
  logic [1:0] stg [STAGES];
  logic [1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= 2'b11;
        else         stg[g] <= {scl_i, sda_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= 2'b11;
        else         stg[g] <= stg[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 2'b11;
    else         prev_q <= stg[STAGES-1];

  logic scl_now, sda_now, scl_old, sda_old, scl_steady;
  assign scl_now    = stg[STAGES-1][1];
  assign sda_now    = stg[STAGES-1][0];
  assign scl_old    = prev_q[1];
  assign sda_old    = prev_q[0];
  assign scl_steady = scl_now & scl_old;

  always_comb begin
    ev_o.start    = scl_steady & sda_old & ~sda_now;
    ev_o.stop     = scl_steady & ~sda_old & sda_now;
    ev_o.scl_rise = scl_now & ~scl_old;
    ev_o.sda      = sda_now;
  end

  a_r11_events_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_o.start, ev_o.stop, ev_o.scl_rise}));
endmodule

// File: rtl/i2c_mon_clk_cnt.sv
module i2c_mon_clk_cnt #(
  parameter  int BYTE_BITS = 8,
  localparam int ACK_CLK   = BYTE_BITS + 1,
  localparam int CNT_W     = $clog2(ACK_CLK + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  i2c_mon_pkg::bus_ev_t ev_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 ninth_rise_o,  // this edge is the acknowledge clock
  output logic                 wrap_rise_o,   // first clock of the next byte
  output logic                 addr_rise_o    // first clock after start/stop
);
  localparam logic [CNT_W-1:0] ACK_V = CNT_W'(ACK_CLK);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!en_i)                    cnt_q <= '0;
    else if (ev_i.start || ev_i.stop)  cnt_q <= '0;
    else if (ev_i.scl_rise)            cnt_q <= (cnt_q == ACK_V) ? ONE_V : cnt_q + ONE_V;
  end

  assign cnt_o        = cnt_q;
  assign ninth_rise_o = ev_i.scl_rise && (cnt_q == ACK_V - ONE_V);
  assign wrap_rise_o  = ev_i.scl_rise && (cnt_q == ACK_V);
  assign addr_rise_o  = ev_i.scl_rise && (cnt_q == '0);

  a_r9_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ACK_V);
  a_r9_cnt_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ev_i.scl_rise && cnt_q == ACK_V) |=> cnt_q == ONE_V);
  a_r9_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.start || ev_i.stop) |=> cnt_q == '0);
  a_r8_cnt_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/i2c_mon_flags.sv
module i2c_mon_flags (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 rel_i,
  input  i2c_mon_pkg::bus_ev_t ev_i,
  input  logic                 ninth_rise_i,
  input  logic                 wrap_rise_i,
  input  logic                 addr_rise_i,
  output logic                 start_o,
  output logic                 stop_o,
  output logic                 ack_o
);
  logic start_q, stop_q, ack_q, arm_q;
  logic ack_set, sa_clr, stop_clr;

  assign ack_set  = ninth_rise_i & ~ev_i.sda;
  assign sa_clr   = ev_i.stop | wrap_rise_i | rel_i;
  assign stop_clr = arm_q & addr_rise_i;

  // set terms are ORed last so a coincident set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0; stop_q <= 1'b0; ack_q <= 1'b0; arm_q <= 1'b0;
    end else if (!en_i) begin
      start_q <= 1'b0; stop_q <= 1'b0; ack_q <= 1'b0; arm_q <= 1'b0;
    end else begin
      start_q <= ev_i.start | (start_q & ~sa_clr);
      ack_q   <= ack_set    | (ack_q & ~sa_clr);
      stop_q  <= ev_i.stop  | (stop_q & ~stop_clr);
      if (ev_i.stop)                 arm_q <= 1'b0;
      else if (ev_i.start && stop_q) arm_q <= 1'b1;
      else if (addr_rise_i)          arm_q <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign ack_o   = ack_q;

  a_r1_start_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ev_i.start) |=> start_q);
  a_r2_stop_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ev_i.stop) |=> stop_q);
  a_r3_ack_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ninth_rise_i && !ev_i.sda) |=> ack_q);
  a_r4_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.stop |=> (!start_q && !ack_q));
  a_r5_wrap_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_rise_i |=> (!start_q && !ack_q));
  a_r6_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !ev_i.start && !ack_set) |=> (!start_q && !ack_q));
  a_r7_start_keeps_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stop_q && ev_i.start) |=> stop_q);
  a_r8_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!start_q && !stop_q && !ack_q));
endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor #(
  parameter  int BYTE_BITS   = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(BYTE_BITS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rel_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             ack_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic             ack_slot_o
);
  i2c_mon_pkg::bus_ev_t ev;
  logic ninth_rise, wrap_rise, addr_rise;

  i2c_mon_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i, .ev_o(ev)
  );

  i2c_mon_clk_cnt #(.BYTE_BITS(BYTE_BITS)) i_cnt (
    .clk_i, .rst_ni, .en_i, .ev_i(ev), .cnt_o(bit_cnt_o),
    .ninth_rise_o(ninth_rise), .wrap_rise_o(wrap_rise), .addr_rise_o(addr_rise)
  );

  i2c_mon_flags i_flags (
    .clk_i, .rst_ni, .en_i, .rel_i, .ev_i(ev),
    .ninth_rise_i(ninth_rise), .wrap_rise_i(wrap_rise), .addr_rise_i(addr_rise),
    .start_o, .stop_o, .ack_o
  );

  assign ack_slot_o = (bit_cnt_o == CNT_W'(BYTE_BITS + 1));

  a_r9_slot_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_slot_o |-> ack_slot_o == (ninth_rise ? 1'b0 : 1'b1) || wrap_rise);
endmodule

// File: tb/test_i2c_cond_monitor.sv
module test_i2c_cond_monitor;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, rel = 1'b0, scl = 1'b1, sda = 1'b1;
  logic st_o, sp_o, ak_o, slot_o;
  logic [3:0] cnt_o;
  int n_chk = 0, n_bad = 0;

  // bench model
  bit m_start, m_stop, m_ack, m_arm;
  int m_cnt;

  always #10 clk = ~clk;

  i2c_cond_monitor i_i2c_cond_monitor (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rel_i(rel), .scl_i(scl), .sda_i(sda),
    .start_o(st_o), .stop_o(sp_o), .ack_o(ak_o), .bit_cnt_o(cnt_o), .ack_slot_o(slot_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " start"}, int'(st_o), int'(m_start));
    chk({tag, " stop"},  int'(sp_o), int'(m_stop));
    chk({tag, " ack"},   int'(ak_o), int'(m_ack));
    chk({tag, " cnt R9"}, int'(cnt_o), m_cnt);
    chk({tag, " slot R9"}, int'(slot_o), int'(m_cnt == 9));
  endtask

  function automatic void model(bit os, bit od, bit ns, bit nd);
    bit is_start, is_stop, is_rise;
    is_start = os && ns && od && !nd;
    is_stop  = os && ns && !od && nd;
    is_rise  = !os && ns;
    if (!en) return;
    if (is_start) begin
      m_start = 1; if (m_stop) m_arm = 1; m_cnt = 0;
    end else if (is_stop) begin
      m_stop = 1; m_start = 0; m_ack = 0; m_arm = 0; m_cnt = 0;
    end else if (is_rise) begin
      if (m_cnt == 0 && m_arm) begin m_stop = 0; m_arm = 0; end
      if (m_cnt == 9) begin m_start = 0; m_ack = 0; m_cnt = 1; end
      else m_cnt++;
      if (m_cnt == 9 && !nd) m_ack = 1;
    end
  endfunction

  task automatic step(bit ns, bit nd, string tag);
    @(negedge clk);
    model(scl, sda, ns, nd);
    scl = ns; sda = nd;
    repeat (4) @(negedge clk);
    chk_all(tag);
  endtask

  task automatic pulse_rel(string tag);
    @(negedge clk); rel = 1'b1;
    @(negedge clk); rel = 1'b0;
    if (en) begin m_start = 0; m_ack = 0; end
    @(negedge clk);
    chk_all(tag);
  endtask

  task automatic set_en(bit v, string tag);
    @(negedge clk); en = v;
    if (!v) begin m_start = 0; m_stop = 0; m_ack = 0; m_arm = 0; m_cnt = 0; end
    repeat (2) @(negedge clk);
    chk_all(tag);
  endtask

  task automatic do_start(string tag);
    if (scl && !sda) step(0, 0, tag);
    if (!scl) begin step(0, 1, tag); step(1, 1, tag); end
    step(1, 0, tag);
    step(0, 0, tag);
  endtask

  task automatic do_stop(string tag);
    if (scl) step(0, sda, tag);
    step(0, 0, tag);
    step(1, 0, tag);
    step(1, 1, tag);
  endtask

  task automatic send_bit(bit b, string tag);
    if (scl) step(0, sda, tag);
    step(0, b, tag);
    step(1, b, tag);
    step(0, b, tag);
  endtask

  task automatic send_byte(logic [7:0] d, bit nack, string tag);
    for (int i = 7; i >= 0; i--) send_bit(d[i], tag);
    send_bit(nack, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk_all("R10 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R10 after reset");

    // R1 exact latency probe
    @(negedge clk); model(1, 1, 1, 0); sda = 0;
    repeat (2) @(posedge clk); #1;
    chk("R1 start not yet after 2 edges", int'(st_o), 0);
    @(posedge clk); #1;
    chk("R1 start after 3 edges", int'(st_o), 1);
    repeat (2) @(negedge clk);
    step(0, 0, "R1");

    // address byte, acked
    for (int i = 7; i >= 0; i--) send_bit(i[0], "R5 address byte");
    chk("R5 start held in address byte", int'(st_o), 1);
    chk("R9 count after 8 bits", int'(cnt_o), 8);
    step(0, 0, "R3"); step(1, 0, "R3 ninth clock");
    chk("R3 ack set on low SDA", int'(ak_o), 1);
    chk("R9 slot on ninth", int'(slot_o), 1);
    step(0, 0, "R3");
    step(0, 1, "R11 sda change scl low");
    chk("R11 no stop on sda rise scl low", int'(sp_o), 0);
    step(1, 1, "R5 first clock next byte");
    chk("R5 start cleared", int'(st_o), 0);
    chk("R5 ack cleared", int'(ak_o), 0);
    chk("R9 wrap to 1", int'(cnt_o), 1);
    for (int i = 0; i < 7; i++) send_bit(1'b0, "R9");
    send_bit(1'b1, "R3 nack");
    chk("R3 nack leaves ack clear", int'(ak_o), 0);
    send_byte(8'h3c, 1'b0, "R3 acked byte");
    chk("R3 ack before stop", int'(ak_o), 1);
    do_stop("R2");
    chk("R2 stop set", int'(sp_o), 1);
    chk("R4 ack cleared by stop", int'(ak_o), 0);
    chk("R9 count zero after stop", int'(cnt_o), 0);

    // R7 stop survives new start
    do_start("R7");
    chk("R7 stop kept over start", int'(sp_o), 1);
    pulse_rel("R6 release");
    chk("R6 start cleared by release", int'(st_o), 0);
    chk("R6 stop kept by release", int'(sp_o), 1);
    step(1, 0, "R7 first address clock");
    chk("R7 stop cleared", int'(sp_o), 0);
    do_stop("R2");
    do_start("R4");
    send_byte(8'h81, 1'b0, "R4");
    do_stop("R4 stop after ack");
    chk("R4 start cleared", int'(st_o), 0);

    // R8 enable
    do_start("R8");
    set_en(0, "R8 disable");
    chk("R8 flags cleared", int'(st_o | sp_o | ak_o), 0);
    do_stop("R8 ignored while off");
    do_start("R8 ignored while off");
    chk("R8 start ignored", int'(st_o), 0);
    set_en(1, "R8 enable");

    // constrained random frames
    for (int f = 0; f < 30; f++) begin
      do_start("rand frame");
      for (int b = 0; b < int'($urandom_range(1, 3)); b++) begin
        send_byte(8'($urandom), 1'($urandom), "rand byte");
        if ($urandom_range(0, 5) == 0) pulse_rel("R6 rand release");
      end
      if ($urandom_range(0, 7) == 0) set_en(0, "R8 rand off");
      if (!en) set_en(1, "R8 rand on");
      do_stop("rand stop");
    end

    // random walk on the lines
    for (int k = 0; k < 500; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 45)      step(~scl, sda, "walk scl");
      else if (r < 85) step(scl, ~sda, "walk sda");
      else if (r < 93) pulse_rel("R6 walk release");
      else             set_en(~en, "R8 walk enable");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule